// File: doc/BRIEF.md
# Text-to-grid puzzle loader

This block takes a puzzle board written as plain ASCII text and builds a 9x9 number-place grid in registers. Text arrives one byte per clock under a valid/ready handshake. Layout characters such as spaces, line breaks, vertical bars, dashes and plus signs are skipped. Every other character becomes exactly one cell. A digit from one to nine is stored as that value, and any other character marks the cell as empty (value 0). Cells are filled in row order, from the first row left to right down to the last cell of the last row.

After the last cell is written, the block raises a one-cycle completion pulse and a sticky full flag. It then refuses further bytes until a synchronous clear starts a new board. The whole board is always visible on a wide parallel output, so a downstream rule checker or solver can read it directly.

Top module: `sudoku_grid_loader`

## Requirements
- R1: After reset (rst_n low) or a cycle with clr high, every cell reads 0, full and done are low, and in_ready is high again once clr is low.
- R2: The bytes 0x20 (space), 0x09 (tab), 0x0D (CR), 0x0A (LF), 0x7C ('|'), 0x2D ('-') and 0x2B ('+') are accepted but write no cell and do not advance the fill position, even when they arrive back to back with cell characters.
- R3: An accepted byte 0x31..0x39 ('1'..'9') writes the value 1..9 into the current cell and advances the position.
- R4: Any other accepted byte (for example '.', 'x', '0', '*') writes 0 into the current cell and advances the position.
- R5: Cells fill in row-major order. The k-th cell (k = 9*row + col, both counted from 0) sits at grid bits [4k+3:4k], so the first cell is grid[3:0] and the last cell is grid[323:320].
- R6: grid shows a written cell in the cycle right after the clock edge that accepted its byte.
- R7: in_ready stays high until the 81st cell is written and then stays low until a clear. Bytes offered while full change nothing.
- R8: done is high for exactly one cycle, the cycle right after the edge that writes the 81st cell. full rises in that same cycle and stays high until a clear.
- R9: While clr is high, in_ready is low and any offered byte is discarded. The clear takes effect and the byte writes no cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous board clear, active high |
| in_valid | input | 1 | Byte on in_data is offered |
| in_data | input | 8 | ASCII character |
| in_ready | output | 1 | Block takes the offered byte this cycle |
| done | output | 1 | One-cycle pulse after the last cell is written |
| full | output | 1 | Board complete, held until clear |
| grid | output | 324 | All cells, 4 bits each, row-major from bit 0 |

## Verification
A board clear and a character offer can land on the same clock edge. The bench provokes this by raising clr while a digit is valid. It then expects in_ready to read low in that cycle and the grid to read all zero afterwards, with no cell taken from the byte. The other collision is a run of separators pressed against cell characters with no idle cycles in between. It is judged by comparing every cell after each byte against an independent text-walk model.

// File: rtl/sgl_pkg.sv
// Shared types for the text-to-grid loader.
// Assumes: ASCII input; a cell value fits in the chosen cell width.
package sgl_pkg;
    typedef enum logic [1:0] {
        CH_DROP  = 2'd0,   // layout character, no cell consumed
        CH_EMPTY = 2'd1,   // consumes a cell, stores 0
        CH_GIVEN = 2'd2    // consumes a cell, stores digit value
    } char_kind_e;
endpackage

// File: rtl/sgl_char_class.sv
// Character classifier: sorts one ASCII byte into skip / empty / given
// and yields the cell value. Purely combinational.
// Assumes: CELL_W >= 4 so that the value nine fits.
module sgl_char_class
    import sgl_pkg::*;
#(
    parameter int CELL_W = 4
) (
    input  logic [7:0]        ch,
    output char_kind_e        kind,
    output logic [CELL_W-1:0] value
);
    localparam logic [7:0] ASCII_ONE  = 8'h31;
    localparam logic [7:0] ASCII_NINE = 8'h39;
    localparam logic [7:0] ASCII_ZERO = 8'h30;

    logic [7:0] offset;
    assign offset = ch - ASCII_ZERO;

    // Classify the byte and derive the stored value.
    always_comb begin
        kind  = CH_EMPTY;
        value = '0;
        unique case (ch)
            8'h20, 8'h09, 8'h0D, 8'h0A, 8'h7C, 8'h2D, 8'h2B: kind = CH_DROP;
            default: begin
                if (ch >= ASCII_ONE && ch <= ASCII_NINE) begin
                    kind  = CH_GIVEN;
                    value = offset[CELL_W-1:0];
                end
            end
        endcase
    end
endmodule

// File: rtl/sgl_cell_ptr.sv
// Fill-position counter with completion tracking. Counts cells written,
// raises full when the last one is written and pulses done once.
// Assumes: advance is never high while full is high.
module sgl_cell_ptr #(
    parameter int CELLS = 81,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             advance,
    output logic [CNT_W-1:0] ptr,
    output logic             full,
    output logic             done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CELLS - 1);

    // Step the position and flag completion on the last write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr  <= '0;
            full <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (advance) begin
                ptr <= ptr + 1'b1;
                if (ptr == LAST) begin
                    full <= 1'b1;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sgl_cell_store.sv
// Cell storage: one register per cell, written at the addressed
// position, all cleared together.
// Assumes: waddr < CELLS whenever we is high.
module sgl_cell_store #(
    parameter int CELLS  = 81,
    parameter int CELL_W = 4,
    parameter int CNT_W  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    we,
    input  logic [CNT_W-1:0]        waddr,
    input  logic [CELL_W-1:0]       wdata,
    output logic [CELLS*CELL_W-1:0] cells
);
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        // Hold one cell; load it when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                cells[i*CELL_W +: CELL_W] <= '0;
            end else if (we && waddr == CNT_W'(i)) begin
                cells[i*CELL_W +: CELL_W] <= wdata;
            end
        end
    end
endmodule

// File: rtl/sudoku_grid_loader.sv
// Top: turns an ASCII byte stream into a row-major grid of cells.
// Layout characters are skipped; digits 1..9 become givens; others empty.
// Assumes: in_data is stable while in_valid is high and not taken.
module sudoku_grid_loader
    import sgl_pkg::*;
#(
    parameter int ROWS   = 9,
    parameter int COLS   = 9,
    parameter int CELL_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         in_valid,
    input  logic [7:0]                   in_data,
    output logic                         in_ready,
    output logic                         done,
    output logic                         full,
    output logic [ROWS*COLS*CELL_W-1:0]  grid
);
    localparam int CELLS  = ROWS * COLS;
    localparam int GRID_W = CELLS * CELL_W;
    localparam int CNT_W  = $clog2(CELLS + 1);

    char_kind_e        kind;
    logic [CELL_W-1:0] value;
    logic [CNT_W-1:0]  ptr;
    logic              take;
    logic              advance;

    assign in_ready = !full && !clr;
    assign take     = in_valid && in_ready;
    assign advance  = take && (kind != CH_DROP);

    sgl_char_class #(.CELL_W(CELL_W)) u_class (
        .ch    (in_data),
        .kind  (kind),
        .value (value)
    );

    sgl_cell_ptr #(.CELLS(CELLS), .CNT_W(CNT_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .advance (advance),
        .ptr     (ptr),
        .full    (full),
        .done    (done)
    );

    sgl_cell_store #(.CELLS(CELLS), .CELL_W(CELL_W), .CNT_W(CNT_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .we    (advance),
        .waddr (ptr),
        .wdata (value),
        .cells (grid)
    );
endmodule

// File: rtl/sgl_checker.sv
// Protocol and state checks for the loader, attached by bind.
// Assumes: observes the top-level ports only.
module sgl_checker #(
    parameter int GRID_W = 324
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              in_valid,
    input logic [7:0]        in_data,
    input logic              in_ready,
    input logic              done,
    input logic              full,
    input logic [GRID_W-1:0] grid
);
    function automatic logic is_layout(input logic [7:0] c);
        return c == 8'h20 || c == 8'h09 || c == 8'h0D || c == 8'h0A ||
               c == 8'h7C || c == 8'h2D || c == 8'h2B;
    endfunction

    assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (grid == '0 && !full && !done));

    assert_layout_keeps_grid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && is_layout(in_data)) |=> $stable(grid));

    assert_ready_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !in_ready);

    assert_full_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> $stable(grid));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_with_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> full);

    assert_full_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> full);

    assert_clear_refuses_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !in_ready);
endmodule

bind sudoku_grid_loader sgl_checker #(.GRID_W(GRID_W)) u_sgl_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .done     (done),
    .full     (full),
    .grid     (grid)
);

// File: tb/test_sudoku_grid_loader.sv
module test_sudoku_grid_loader;
    localparam int CELLS  = 81;
    localparam int GRID_W = CELLS * 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = 8'h00;
    logic              in_ready;
    logic              done;
    logic              full;
    logic [GRID_W-1:0] grid;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [GRID_W-1:0] g;
        logic              f;
        logic              d;
        string             tag;
    } exp_t;
    exp_t sb[$];

    // Reference model state
    logic [GRID_W-1:0] m_grid = '0;
    int                m_cnt  = 0;
    logic              m_full = 1'b0;

    always #5 clk = ~clk;

    sudoku_grid_loader i_sudoku_grid_loader (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .done(done),
        .full(full), .grid(grid)
    );

    function automatic logic skip_char(input logic [7:0] c);
        return c == " " || c == 8'h09 || c == 8'h0D || c == 8'h0A ||
               c == "|" || c == "-" || c == "+";
    endfunction

    // Driver: apply one cycle of stimulus, predict, queue expectation.
    task automatic step(input logic v, input logic [7:0] ch, input logic c, input string tag);
        logic exp_rdy;
        logic dn;
        exp_t e;
        @(negedge clk);
        in_valid = v; in_data = ch; clr = c;
        #1;
        exp_rdy = !m_full && !c;
        tests++;
        if (in_ready !== exp_rdy) begin
            fails++;
            $display("FAIL %s in_ready actual=%b expected=%b", tag, in_ready, exp_rdy);
        end
        dn = 1'b0;
        if (c) begin
            m_grid = '0; m_cnt = 0; m_full = 1'b0;
        end else if (v && exp_rdy && !skip_char(ch)) begin
            m_grid[m_cnt*4 +: 4] = (ch >= "1" && ch <= "9") ? 4'(ch - "0") : 4'd0;
            m_cnt++;
            if (m_cnt == CELLS) begin m_full = 1'b1; dn = 1'b1; end
        end
        e.g = m_grid; e.f = m_full; e.d = dn; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare outputs just after each edge with the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                tests++;
                if (grid !== e.g || full !== e.f || done !== e.d) begin
                    fails++;
                    $display("FAIL %s grid=%h full=%b done=%b expected grid=%h full=%b done=%b",
                             e.tag, grid, full, done, e.g, e.f, e.d);
                end
            end
        end
    end

    // Feed one full board with layout characters and varied empties.
    task automatic feed_board();
        for (int r = 0; r < 9; r++) begin
            if (r == 1) step(1'b1, 8'h09, 1'b0, "R2 tab");
            for (int col = 0; col < 9; col++) begin
                logic [7:0] ch;
                if ((r + col) % 4 == 0)
                    ch = (r % 3 == 0) ? "." : (r % 3 == 1) ? "x" : ((col == 4) ? "*" : "0");
                else
                    ch = 8'(((r*3 + r/3 + col) % 9) + 1 + 48);
                if (r == 8 && col == 8)
                    step(1'b1, ch, 1'b0, "R8 last cell");
                else if (ch >= "1" && ch <= "9")
                    step(1'b1, ch, 1'b0, "R3 R5 R6 digit");
                else
                    step(1'b1, ch, 1'b0, "R4 R5 R6 empty");
                if (col == 2 || col == 5) step(1'b1, "|", 1'b0, "R2 bar");
            end
            step(1'b1, 8'h0D, 1'b0, "R2 cr");
            step(1'b1, 8'h0A, 1'b0, "R2 lf");
            if (r == 2 || r == 5) begin
                for (int k = 0; k < 11; k++)
                    step(1'b1, (k == 3 || k == 7) ? "+" : "-", 1'b0, "R2 rule");
                step(1'b1, 8'h0A, 1'b0, "R2 lf");
            end
        end
    endtask

    // Watchdog
    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        tests++;
        if (grid !== '0 || full !== 1'b0 || done !== 1'b0 || in_ready !== 1'b1) begin
            fails++;
            $display("FAIL R1 reset grid=%h full=%b done=%b ready=%b expected 0/0/0/1",
                     grid, full, done, in_ready);
        end

        // Layout bytes back to back, then a digit into the first cell.
        step(1'b1, 8'h09, 1'b0, "R2 back to back");
        step(1'b1, 8'h0D, 1'b0, "R2 back to back");
        step(1'b1, "|",   1'b0, "R2 back to back");
        step(1'b1, "-",   1'b0, "R2 back to back");
        step(1'b1, "+",   1'b0, "R2 back to back");
        step(1'b1, " ",   1'b0, "R2 back to back");
        step(1'b1, "7",   1'b0, "R3 R5 first cell");
        step(1'b1, 8'h0A, 1'b0, "R2 after digit");
        step(1'b1, "0",   1'b0, "R4 zero char");
        step(1'b0, "5",   1'b0, "R6 invalid ignored");

        // Clear, then a full board.
        step(1'b0, 8'h00, 1'b1, "R1 clear");
        feed_board();
        step(1'b0, 8'h00, 1'b0, "R8 done drops");
        step(1'b1, "3",   1'b0, "R7 refused while full");
        step(1'b1, ".",   1'b0, "R7 refused while full");
        step(1'b0, 8'h00, 1'b0, "R8 full held");

        // Clear colliding with an offered digit.
        step(1'b1, "5",   1'b1, "R9 clear with byte");
        step(1'b0, 8'h00, 1'b0, "R1 after clear");
        step(1'b1, "9",   1'b0, "R3 R5 restart");
        step(1'b0, 8'h00, 1'b0, "R6 idle");
        step(1'b0, 8'h00, 1'b0, "R6 idle");
        repeat (3) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule